// File: doc/BRIEF.md
# Traffic Store Port Responder

This block is the shared port store that sits between a bus-side frame engine and a processor. The processor fills a word-organised data memory and a small table of port descriptors through a simple memory-mapped interface. Each descriptor names a 12-bit bus port address, says whether the port is a source (answered by this node) or a sink, and locates the port's data by a start word and a size code.

The frame decoder reports each received master frame as a one-cycle strobe together with the polled port address. Once reception has been enabled by software, every such frame sets a flag for the processor and latches the polled address. If the address matches a source descriptor with a legal size, the block opens a reply: it announces the number of 16-bit words and then returns one word per read strobe from the transmitter, taken from consecutive memory words starting at the descriptor's start word. The data memory has two ports, so the processor can update port data while a reply is being read out.

Top module: `traffic_store_responder`

## Requirements
- R1: After reset the receive-enable bit, the frame flag, the reply strobe and the busy output are 0, and every control and descriptor register reads back as 0, so every descriptor starts as a sink.
- R2: A processor access with address bit MEM_AW = 1 reaches data word addr[MEM_AW-1:0], with bit MEM_AW = 0 it reaches register addr[MEM_AW-1:0]; read data appears on cpu_rdata_o in the cycle after the request. Register 0 bit 0 is receive enable, register 2+2i is descriptor i's header and register 3+2i its start word (zero-extended on read).
- R3: While receive enable is 0, a master frame strobe neither sets the flag nor opens a reply.
- R4: While receive enable is 1, every master frame strobe sets irq_o in the next cycle and register 1 reads {flag in bit 15, zeros in bits 14:12, polled address in bits 11:0}; a processor write to register 1 clears the flag.
- R5: A strobe whose address equals a descriptor header's bits 11:0, with header bit 15 = 1 (source) and size code in bits 14:12 of 0 to 4, makes sf_start_o high for exactly the next cycle, sets sf_busy_o, and drives sf_nwords_o = 2^code (16·2^code bits).
- R6: During a reply each sf_rd_i strobe returns, in the next cycle on sf_data_o, the word at start + k for the k-th read; sf_busy_o falls after the read of the last word.
- R7: A strobe that matches no descriptor, matches a sink (bit 15 = 0), or matches a size code of 5 to 7 opens no reply; the flag is still set.
- R8: When several source descriptors carry the polled address, the one with the lowest index supplies the start word and length.
- R9: A strobe that arrives while a reply is open does not restart it or change its length or data order.
- R10: sf_rd_i while no reply is open changes neither sf_data_o nor where the next reply starts.
- R11: The word address of a reply wraps from the last memory word to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor access strobe |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | MEM_AW+1 | Processor word address, top bit selects memory |
| cpu_wdata_i | input | 16 | Processor write data |
| cpu_rdata_o | output | 16 | Processor read data, one cycle after request |
| irq_o | output | 1 | Master-frame-received flag |
| mf_valid_i | input | 1 | Master frame received strobe |
| mf_addr_i | input | 12 | Polled port address of that frame |
| sf_start_o | output | 1 | One-cycle strobe: a reply has opened |
| sf_nwords_o | output | 5 | Words in the open reply |
| sf_busy_o | output | 1 | Reply open |
| sf_rd_i | input | 1 | Transmitter word read strobe |
| sf_data_o | output | 16 | Reply word, valid the cycle after sf_rd_i |

## Verification
The bench builds the block with four descriptors and a 64-word memory, which makes every size code, every descriptor slot and the memory end reachable in a short run. It sweeps all eight size codes across all four slots with start words spread over the memory, including ones that cross the top and wrap, and compares each streamed word with an arithmetic fill pattern. Sink ports, unmatched addresses, duplicated addresses, polls during a reply and stray read strobes are exercised separately.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int PADDR_W = 12;
  localparam int DATA_W  = 16;
  localparam int NW_W    = 5;

  typedef struct packed {
    logic               src;
    logic [2:0]         size;
    logic [PADDR_W-1:0] paddr;
  } desc_hdr_t;

  function automatic logic size_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic [NW_W-1:0] size_words(input logic [2:0] code);
    logic [NW_W-1:0] w;
    case (code)
      3'd0:    w = 5'd1;
      3'd1:    w = 5'd2;
      3'd2:    w = 5'd4;
      3'd3:    w = 5'd8;
      3'd4:    w = 5'd16;
      default: w = 5'd0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tsr_dpram.sv
module tsr_dpram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic [AW-1:0] b_addr_i,
  output logic [DW-1:0] b_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_en_i) begin
      if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
      a_rdata_o <= mem_q[a_addr_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (b_en_i) b_rdata_o <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/tsr_regs.sv
module tsr_regs
  import tsr_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MEM_AW    = 10
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic                                rd_i,
  input  logic [MEM_AW-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  input  logic                                mf_valid_i,
  input  logic [PADDR_W-1:0]                  mf_addr_i,
  output logic                                rx_en_o,
  output logic                                irq_o,
  output desc_hdr_t [NUM_PORTS-1:0]           hdr_o,
  output logic [NUM_PORTS-1:0][MEM_AW-1:0]    start_o
);
  localparam int REG_CTRL = 0;
  localparam int REG_POLL = 1;
  localparam int REG_DESC = 2;

  logic               rx_en_q, flag_q;
  logic [PADDR_W-1:0] poll_q;
  logic               capture;

  assign capture = mf_valid_i && rx_en_q;
  assign rx_en_o = rx_en_q;
  assign irq_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q <= 1'b0;
      flag_q  <= 1'b0;
      poll_q  <= '0;
    end else begin
      if (wr_i && addr_i == MEM_AW'(REG_CTRL)) rx_en_q <= wdata_i[0];
      // a new frame wins over a same-cycle clear
      if (capture) begin
        flag_q <= 1'b1;
        poll_q <= mf_addr_i;
      end else if (wr_i && addr_i == MEM_AW'(REG_POLL)) begin
        flag_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_desc
    localparam int HOFF = REG_DESC + 2 * i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hdr_o[i]   <= '0;
        start_o[i] <= '0;
      end else if (wr_i) begin
        if (addr_i == MEM_AW'(HOFF))     hdr_o[i]   <= desc_hdr_t'(wdata_i);
        if (addr_i == MEM_AW'(HOFF + 1)) start_o[i] <= wdata_i[MEM_AW-1:0];
      end
    end
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (addr_i == MEM_AW'(REG_CTRL)) rmux = {{(DATA_W-1){1'b0}}, rx_en_q};
    if (addr_i == MEM_AW'(REG_POLL)) rmux = {flag_q, 3'b000, poll_q};
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr_i == MEM_AW'(REG_DESC + 2 * i))     rmux = DATA_W'(hdr_o[i]);
      if (addr_i == MEM_AW'(REG_DESC + 2 * i + 1)) rmux = DATA_W'(start_o[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rmux;
  end
endmodule

// File: rtl/tsr_match.sv
module tsr_match
  import tsr_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MEM_AW    = 10
) (
  input  desc_hdr_t [NUM_PORTS-1:0]        hdr_i,
  input  logic [NUM_PORTS-1:0][MEM_AW-1:0] start_i,
  input  logic [PADDR_W-1:0]               addr_i,
  output logic                             hit_o,
  output logic [MEM_AW-1:0]                start_o,
  output logic [NW_W-1:0]                  words_o
);
  logic [NUM_PORTS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_cmp
    assign hit_vec[i] = hdr_i[i].src && size_ok(hdr_i[i].size) &&
                        (hdr_i[i].paddr == addr_i);
  end

  // scan downwards so the lowest index is applied last
  always_comb begin
    hit_o   = 1'b0;
    start_o = '0;
    words_o = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_o   = 1'b1;
        start_o = start_i[i];
        words_o = size_words(hdr_i[i].size);
      end
    end
  end
endmodule

// File: rtl/tsr_reply.sv
module tsr_reply
  import tsr_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              hit_i,
  input  logic [MEM_AW-1:0] start_i,
  input  logic [NW_W-1:0]   words_i,
  input  logic              rd_i,
  output logic              busy_o,
  output logic              start_o,
  output logic [NW_W-1:0]   nwords_o,
  output logic              mem_en_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  logic [MEM_AW-1:0] ptr_q;
  logic [NW_W-1:0]   rem_q;

  assign mem_en_o   = busy_o && rd_i;
  assign mem_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      start_o  <= 1'b0;
      nwords_o <= '0;
      ptr_q    <= '0;
      rem_q    <= '0;
    end else begin
      start_o <= 1'b0;
      if (!busy_o) begin
        if (poll_i && hit_i) begin
          busy_o   <= 1'b1;
          start_o  <= 1'b1;
          nwords_o <= words_i;
          ptr_q    <= start_i;
          rem_q    <= words_i;
        end
      end else if (rd_i) begin
        ptr_q <= ptr_q + 1'b1;  // wraps at memory end
        rem_q <= rem_q - 1'b1;
        if (rem_q == NW_W'(1)) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/traffic_store_responder.sv
module traffic_store_responder
  import tsr_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MEM_AW    = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [MEM_AW:0]    cpu_addr_i,
  input  logic [15:0]        cpu_wdata_i,
  output logic [15:0]        cpu_rdata_o,
  output logic               irq_o,
  input  logic               mf_valid_i,
  input  logic [11:0]        mf_addr_i,
  output logic               sf_start_o,
  output logic [4:0]         sf_nwords_o,
  output logic               sf_busy_o,
  input  logic               sf_rd_i,
  output logic [15:0]        sf_data_o
);
  logic                             sel_mem, sel_mem_q;
  logic [15:0]                      reg_rdata, mem_rdata;
  logic                             rx_en;
  desc_hdr_t [NUM_PORTS-1:0]        hdr;
  logic [NUM_PORTS-1:0][MEM_AW-1:0] start_w;
  logic                             hit;
  logic [MEM_AW-1:0]                hit_start;
  logic [NW_W-1:0]                  hit_words;
  logic                             b_en;
  logic [MEM_AW-1:0]                b_addr;

  assign sel_mem = cpu_addr_i[MEM_AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_mem_q <= 1'b0;
    else if (cpu_req_i) sel_mem_q <= sel_mem;
  end

  assign cpu_rdata_o = sel_mem_q ? mem_rdata : reg_rdata;

  tsr_regs #(.NUM_PORTS(NUM_PORTS), .MEM_AW(MEM_AW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cpu_req_i && cpu_we_i && !sel_mem),
    .rd_i       (cpu_req_i && !sel_mem),
    .addr_i     (cpu_addr_i[MEM_AW-1:0]),
    .wdata_i    (cpu_wdata_i),
    .rdata_o    (reg_rdata),
    .mf_valid_i (mf_valid_i),
    .mf_addr_i  (mf_addr_i),
    .rx_en_o    (rx_en),
    .irq_o      (irq_o),
    .hdr_o      (hdr),
    .start_o    (start_w)
  );

  tsr_match #(.NUM_PORTS(NUM_PORTS), .MEM_AW(MEM_AW)) i_match (
    .hdr_i   (hdr),
    .start_i (start_w),
    .addr_i  (mf_addr_i),
    .hit_o   (hit),
    .start_o (hit_start),
    .words_o (hit_words)
  );

  tsr_reply #(.MEM_AW(MEM_AW)) i_reply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .poll_i     (mf_valid_i && rx_en),
    .hit_i      (hit),
    .start_i    (hit_start),
    .words_i    (hit_words),
    .rd_i       (sf_rd_i),
    .busy_o     (sf_busy_o),
    .start_o    (sf_start_o),
    .nwords_o   (sf_nwords_o),
    .mem_en_o   (b_en),
    .mem_addr_o (b_addr)
  );

  tsr_dpram #(.AW(MEM_AW), .DW(16)) i_mem (
    .clk_i     (clk_i),
    .a_en_i    (cpu_req_i && sel_mem),
    .a_we_i    (cpu_we_i),
    .a_addr_i  (cpu_addr_i[MEM_AW-1:0]),
    .a_wdata_i (cpu_wdata_i),
    .a_rdata_o (mem_rdata),
    .b_en_i    (b_en),
    .b_addr_i  (b_addr),
    .b_rdata_o (sf_data_o)
  );
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mf_valid_i,
  input logic        rx_en,
  input logic        irq_o,
  input logic        sf_start_o,
  input logic        sf_busy_o,
  input logic [4:0]  sf_nwords_o,
  input logic        sf_rd_i,
  input logic [15:0] sf_data_o
);
  // R3
  rx_off_no_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_valid_i && !rx_en && !sf_busy_o) |=> !sf_start_o);

  // R4
  flag_from_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mf_valid_i));

  // R5
  start_opens_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sf_busy_o) |-> (sf_start_o && sf_nwords_o != 5'd0));

  // R5
  start_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_start_o |=> !sf_start_o);

  // R9
  busy_poll_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_busy_o && mf_valid_i) |=> (!sf_start_o && $stable(sf_nwords_o)));

  // R10
  idle_read_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sf_busy_o && sf_rd_i) |=> $stable(sf_data_o));
endmodule

bind traffic_store_responder tsr_chk i_tsr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mf_valid_i  (mf_valid_i),
  .rx_en       (rx_en),
  .irq_o       (irq_o),
  .sf_start_o  (sf_start_o),
  .sf_busy_o   (sf_busy_o),
  .sf_nwords_o (sf_nwords_o),
  .sf_rd_i     (sf_rd_i),
  .sf_data_o   (sf_data_o)
);

// File: tb/test_traffic_store_responder.sv
module test_traffic_store_responder;
  localparam int NP = 4;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        irq;
  logic        mf_valid = 1'b0;
  logic [11:0] mf_addr = '0;
  logic        sf_start, sf_busy;
  logic [4:0]  sf_nwords;
  logic        sf_rd = 1'b0;
  logic [15:0] sf_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  traffic_store_responder #(.NUM_PORTS(NP), .MEM_AW(AW)) i_traffic_store_responder (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .irq_o(irq),
    .mf_valid_i(mf_valid), .mf_addr_i(mf_addr),
    .sf_start_o(sf_start), .sf_nwords_o(sf_nwords), .sf_busy_o(sf_busy),
    .sf_rd_i(sf_rd), .sf_data_o(sf_data)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a % DEPTH) * 16'h0101) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = (AW+1)'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input int a, output logic [15:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = (AW+1)'(a);
    @(negedge clk);
    cpu_req = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic set_desc(input int i, input bit src, input int code, input int pa, input int st);
    cpu_wr(2 + 2*i, {src, 3'(code), 12'(pa)});
    cpu_wr(3 + 2*i, 16'(st));
  endtask

  // strobe one master frame; returns at the negedge after its capture edge
  task automatic poll(input int pa);
    @(negedge clk);
    mf_valid = 1'b1; mf_addr = 12'(pa);
    @(negedge clk);
    mf_valid = 1'b0;
  endtask

  task automatic stream(input int st, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(sf_busy == 1'b1, "R6 busy during reply", int'(sf_busy), 1);
      sf_rd = 1'b1;
      @(negedge clk);
      sf_rd = 1'b0;
      chk(sf_data == pat(st + k), req, int'(sf_data), int'(pat(st + k)));
    end
    chk(sf_busy == 1'b0, "R6 busy falls after last word", int'(sf_busy), 0);
  endtask

  task automatic clear_flag();
    cpu_wr(1, 16'h0);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 0 && sf_busy == 0 && sf_start == 0, "R1 outputs idle",
        int'({irq, sf_busy, sf_start}), 0);
    for (int r = 0; r < 2 + 2*NP; r++) begin
      cpu_rd(r, d);
      chk(d == 16'h0, "R1 register reset value", int'(d), 0);
    end

    // R2 memory fill and readback
    for (int a = 0; a < DEPTH; a++) cpu_wr(DEPTH + a, pat(a));
    for (int a = 0; a < DEPTH; a++) begin
      cpu_rd(DEPTH + a, d);
      chk(d == pat(a), "R2 memory readback", int'(d), int'(pat(a)));
    end
    set_desc(0, 1'b1, 1, 12'h014, 16'hFFC4);
    cpu_rd(2, d);
    chk(d == 16'h9014, "R2 header readback", int'(d), 16'h9014);
    cpu_rd(3, d);
    chk(d == 16'h0004, "R2 start readback zero-extended", int'(d), 4);

    // R3 receive disabled
    poll(12'h014);
    chk(sf_start == 0 && sf_busy == 0, "R3 no reply while disabled",
        int'({sf_start, sf_busy}), 0);
    chk(irq == 0, "R3 no flag while disabled", int'(irq), 0);
    cpu_rd(1, d);
    chk(d == 16'h0, "R3 poll register untouched", int'(d), 0);

    cpu_wr(0, 16'h0001);
    cpu_rd(0, d);
    chk(d == 16'h0001, "R2 control readback", int'(d), 1);

    // R5 R6 R7 R11 sweep over size codes and slots
    for (int code = 0; code < 8; code++) begin
      for (int i = 0; i < NP; i++) begin
        int pa, st, n;
        pa = 12'h100 + code*4 + i;
        st = (code*19 + i*17 + 50) % DEPTH;
        n  = (code <= 4) ? (1 << code) : 0;
        set_desc(i, 1'b1, code, pa, st);
        poll(pa);
        chk(irq == 1, "R4 flag set by frame", int'(irq), 1);
        if (n != 0) begin
          chk(sf_start == 1, "R5 start strobe", int'(sf_start), 1);
          chk(int'(sf_nwords) == n, "R5 word count", int'(sf_nwords), n);
          stream(st, n, (st + n > DEPTH) ? "R11 wrapped reply data" : "R6 reply data");
        end else begin
          chk(sf_start == 0 && sf_busy == 0, "R7 illegal size no reply",
              int'({sf_start, sf_busy}), 0);
        end
        cpu_rd(1, d);
        chk(d == {1'b1, 3'b000, 12'(pa)}, "R4 poll register", int'(d),
            int'({1'b1, 3'b000, 12'(pa)}));
        clear_flag();
        chk(irq == 0, "R4 flag cleared by write", int'(irq), 0);
      end
    end

    // R11 explicit wrap at memory end
    set_desc(0, 1'b1, 3, 12'h014, DEPTH - 2);
    poll(12'h014);
    chk(int'(sf_nwords) == 8, "R11 wrap length", int'(sf_nwords), 8);
    stream(DEPTH - 2, 8, "R11 wrap data");
    clear_flag();

    // R7 sink port and unmatched address
    set_desc(1, 1'b0, 2, 12'h2A0, 10);
    poll(12'h2A0);
    chk(sf_start == 0 && sf_busy == 0, "R7 sink no reply", int'({sf_start, sf_busy}), 0);
    chk(irq == 1, "R7 sink still flags", int'(irq), 1);
    clear_flag();
    poll(12'hABC);
    chk(sf_start == 0 && sf_busy == 0, "R7 unmatched no reply", int'({sf_start, sf_busy}), 0);
    cpu_rd(1, d);
    chk(d == 16'h8ABC, "R7 unmatched address latched", int'(d), 16'h8ABC);
    clear_flag();

    // R8 lowest index wins
    set_desc(0, 1'b0, 0, 12'h333, 0);
    set_desc(1, 1'b1, 2, 12'h333, 20);
    set_desc(3, 1'b1, 4, 12'h333, 40);
    poll(12'h333);
    chk(int'(sf_nwords) == 4, "R8 lowest source slot length", int'(sf_nwords), 4);
    stream(20, 4, "R8 lowest source slot data");
    clear_flag();

    // R9 poll during reply
    set_desc(2, 1'b1, 1, 12'h444, 30);
    poll(12'h333);
    chk(int'(sf_nwords) == 4, "R9 reply opened", int'(sf_nwords), 4);
    sf_rd = 1'b1;
    @(negedge clk);
    sf_rd = 1'b0;
    chk(sf_data == pat(20), "R9 first word", int'(sf_data), int'(pat(20)));
    poll(12'h444);
    chk(sf_start == 0, "R9 no restart strobe", int'(sf_start), 0);
    chk(int'(sf_nwords) == 4, "R9 length kept", int'(sf_nwords), 4);
    stream(21, 3, "R9 data order kept");
    clear_flag();

    // R10 stray reads while idle
    d = sf_data;
    for (int k = 0; k < 3; k++) begin
      sf_rd = 1'b1;
      @(negedge clk);
    end
    sf_rd = 1'b0;
    chk(sf_data == d, "R10 idle read keeps data", int'(sf_data), int'(d));
    poll(12'h444);
    chk(sf_start == 1 && int'(sf_nwords) == 2, "R10 reply after idle reads",
        int'({sf_start, sf_nwords}), 6'h22);
    stream(30, 2, "R10 reply starts at start word");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule